// File: doc/BRIEF.md
# Clock Divider Configuration Register Bank

This block holds the three division settings of a clock synthesizer: a reference (input) divider, a feedback divider and a post (output) divider. Software programs them over a 32-bit word-addressed register port. Every write lands in a shadow copy first. A write whose hold flag is clear then moves all three shadow copies into the active settings on the same clock edge. The synthesizer therefore never runs with a half-updated set of ratios.

Each commit starts a model of the loop relocking. The lock flag drops on the commit edge. A down-counter, loaded from a parameter, raises the flag again once it has run out. At commit time the block also checks the new settings. A divider that is not bypassed and whose two counts add up to zero is flagged as an error. The error flag holds its value until the next commit. The active division ratios are driven out on dedicated ports, so the clock generator can use them directly.

The usual sequence for software is to write the reference and feedback words with the hold flag set. It then writes the post-divider word with the hold flag clear, and that write triggers the relock. After that it polls the status word.

Top module: `cdb_clkdiv_bank`

## Requirements
- R1: After reset, words 0, 1 and 2 read 0x0000_2000 (bypass set, hold clear). The status word reads 0x1 (locked, no error), and all three ratio outputs are 1.
- R2: Word address 0 selects the reference divider, 1 the feedback divider, 2 the post divider and 3 the status word. A divider read returns the stored bits 14:0, and bits 31:15 always read as zero.
- R3: A divider write with bit 14 (hold) set changes only that word's shadow copy. The ratio outputs and the lock flag stay as they were.
- R4: A divider write with bit 14 clear commits on that clock edge. The active settings take all three shadow values, including the data of this write, and the new ratios appear on the outputs after that edge.
- R5: A divider word has a low count in bits 5:0, a high count in bits 11:6, an edge bit at 12 and a bypass bit at 13. Its effective ratio is high plus low, or exactly 1 when bypass is set. The edge bit does not change the ratio.
- R6: Status bit 0 and the lock output fall on the commit edge. They stay low for exactly RELOCK_CYCLES clock cycles and are high again after the RELOCK_CYCLES-th following edge.
- R7: A commit made while the lock flag is low restarts the relock delay from the full count.
- R8: Status bit 1 and the error output are set at a commit when any committed divider has bypass clear and high plus low equal to zero. Otherwise they are cleared. They change only at a commit, and relock completes whatever their value.
- R9: A write to word 3 has no effect: no commit, no relock, and no change to any divider word or to the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ratio_ref | output | 7 | Active reference division ratio |
| ratio_fb | output | 7 | Active feedback division ratio |
| ratio_post | output | 7 | Active post division ratio |
| pll_locked | output | 1 | Lock flag, same as status bit 0 |
| cfg_error | output | 1 | Illegal-setting flag, same as status bit 1 |

## Verification
If a shadow copy is corrupted, it shows up on the very next read of that word. If it leaks into the active set too early, a ratio output changes on an edge that carried no commit. A relock counter that is off by one moves the rising edge of the lock flag by a cycle, and a check that samples the exact cycle sees it. A badly latched error flag shows as a status bit that disagrees with the ratios the bench has just committed. All of these faults are visible within one relock window of the write that causes them.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int FIELD_W   = 6;
  localparam int NUM_DIV   = 3;
  localparam int IDX_W     = 2;
  localparam int LOW_LSB   = 0;
  localparam int HIGH_LSB  = FIELD_W;
  localparam int EDGE_BIT  = 2 * FIELD_W;
  localparam int BYP_BIT   = EDGE_BIT + 1;
  localparam int HOLD_BIT  = EDGE_BIT + 2;
  localparam int WORD_W    = HOLD_BIT + 1;
  localparam int RATIO_W   = FIELD_W + 1;

  localparam logic [IDX_W-1:0] IDX_REF  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_FB   = 2'd1;
  localparam logic [IDX_W-1:0] IDX_POST = 2'd2;
  localparam logic [IDX_W-1:0] IDX_STAT = 2'd3;

  typedef logic [WORD_W-1:0] divword_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  localparam divword_t RESET_WORD = divword_t'(1) << BYP_BIT;

  function automatic logic [FIELD_W-1:0] low_cnt(input divword_t w);
    return w[LOW_LSB +: FIELD_W];
  endfunction

  function automatic logic [FIELD_W-1:0] high_cnt(input divword_t w);
    return w[HIGH_LSB +: FIELD_W];
  endfunction

  function automatic logic bypassed(input divword_t w);
    return w[BYP_BIT];
  endfunction

  function automatic logic holds(input divword_t w);
    return w[HOLD_BIT];
  endfunction

  // Effective division: sum of both counts, or one in bypass
  function automatic ratio_t eff_ratio(input divword_t w);
    ratio_t r;
    if (bypassed(w)) r = ratio_t'(1);
    else r = ratio_t'(high_cnt(w)) + ratio_t'(low_cnt(w));
    return r;
  endfunction

  function automatic logic is_illegal(input divword_t w);
    return !bypassed(w) && (eff_ratio(w) == '0);
  endfunction
endpackage

// File: rtl/cdb_shadow_bank.sv
module cdb_shadow_bank
  import cdb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  divword_t                       wr_word,
  output logic [NUM_DIV-1:0][WORD_W-1:0] shadow_o,
  output logic [NUM_DIV-1:0][WORD_W-1:0] active_o,
  output logic [NUM_DIV-1:0][WORD_W-1:0] commit_word_o,
  output logic                           commit_o
);
  logic wr_hit;
  logic commit;
  logic [NUM_DIV-1:0][WORD_W-1:0] shadow_q;
  logic [NUM_DIV-1:0][WORD_W-1:0] shadow_nxt;
  logic [NUM_DIV-1:0][WORD_W-1:0] active_q;

  assign wr_hit = wr_en && (wr_idx < IDX_W'(NUM_DIV));
  assign commit = wr_hit && !holds(wr_word);

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    logic sel;
    assign sel = wr_hit && (wr_idx == IDX_W'(i));
    assign shadow_nxt[i] = sel ? wr_word : shadow_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[i] <= RESET_WORD;
        active_q[i] <= RESET_WORD;
      end else begin
        shadow_q[i] <= shadow_nxt[i];
        if (commit) active_q[i] <= shadow_nxt[i];
      end
    end
  end

  assign shadow_o      = shadow_q;
  assign active_o      = active_q;
  assign commit_word_o = shadow_nxt;
  assign commit_o      = commit;

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));

  // R9
  idle_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(shadow_q));

  // R4
  commit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q == shadow_q));
endmodule

// File: rtl/cdb_relock_timer.sv
module cdb_relock_timer #(
  parameter int RELOCK_CYCLES = 25000,
  localparam int CNT_W = $clog2(RELOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic lock_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic             expire;

  assign expire = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b1;
    end else if (start) begin
      cnt_q  <= CNT_W'(RELOCK_CYCLES);
      lock_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (expire) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;

  // R6
  drop_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !lock_q);

  // R6
  stay_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !start) |=> lock_q);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(RELOCK_CYCLES));

  // R6
  rise_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !$past(start));
endmodule

// File: rtl/cdb_err_eval.sv
module cdb_err_eval
  import cdb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic [NUM_DIV-1:0][WORD_W-1:0] commit_word,
  output logic                           err_o
);
  logic [NUM_DIV-1:0] bad_vec;
  logic               err_q;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_chk
    assign bad_vec[i] = is_illegal(commit_word[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (commit) err_q <= |bad_vec;
  end

  assign err_o = err_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(err_q));
endmodule

// File: rtl/cdb_clkdiv_bank.sv
module cdb_clkdiv_bank
  import cdb_pkg::*;
#(
  parameter int RELOCK_CYCLES = 25000,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [RATIO_W-1:0] ratio_ref,
  output logic [RATIO_W-1:0] ratio_fb,
  output logic [RATIO_W-1:0] ratio_post,
  output logic              pll_locked,
  output logic              cfg_error
);
  logic [NUM_DIV-1:0][WORD_W-1:0] shadow;
  logic [NUM_DIV-1:0][WORD_W-1:0] active;
  logic [NUM_DIV-1:0][WORD_W-1:0] commit_word;
  logic commit_evt;
  logic lock_w;
  logic err_w;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WORD_W];

  cdb_shadow_bank u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (bus_wr),
    .wr_idx        (bus_addr),
    .wr_word       (bus_wdata[WORD_W-1:0]),
    .shadow_o      (shadow),
    .active_o      (active),
    .commit_word_o (commit_word),
    .commit_o      (commit_evt)
  );

  cdb_relock_timer #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (commit_evt),
    .lock_o (lock_w)
  );

  cdb_err_eval u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit_evt),
    .commit_word (commit_word),
    .err_o       (err_w)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_REF:  bus_rdata[WORD_W-1:0] = shadow[0];
      IDX_FB:   bus_rdata[WORD_W-1:0] = shadow[1];
      IDX_POST: bus_rdata[WORD_W-1:0] = shadow[2];
      default:  bus_rdata[1:0] = {err_w, lock_w};
    endcase
  end

  assign ratio_ref  = eff_ratio(active[0]);
  assign ratio_fb   = eff_ratio(active[1]);
  assign ratio_post = eff_ratio(active[2]);
  assign pll_locked = lock_w;
  assign cfg_error  = err_w;

  // R8
  err_vs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (cfg_error == (is_illegal(active[0]) || is_illegal(active[1])
                                  || is_illegal(active[2]))));

  // R5
  ratio_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypassed(active[2]) |-> (ratio_post == RATIO_W'(1)));
endmodule

// File: tb/tb_cdb_clkdiv_bank.sv
module tb_cdb_clkdiv_bank;
  localparam int RLK = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  ratio_ref, ratio_fb, ratio_post;
  logic        pll_locked, cfg_error;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cdb_clkdiv_bank #(.RELOCK_CYCLES(RLK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ratio_ref(ratio_ref),
    .ratio_fb(ratio_fb), .ratio_post(ratio_post), .pll_locked(pll_locked),
    .cfg_error(cfg_error)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int hi, input int lo, input bit edg,
                                     input bit byp, input bit hold);
    return (32'(hold) << 14) | (32'(byp) << 13) | (32'(edg) << 12)
         | (32'(hi & 63) << 6) | 32'(lo & 63);
  endfunction

  function automatic logic [31:0] exp_ratio(input logic [31:0] w);
    if (w[13]) return 32'd1;
    return 32'((w >> 6) & 63) + 32'(w & 63);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // called just after a commit write returns
  task automatic relock_check(input string tag);
    chk({31'd0, pll_locked}, 32'd0, {tag, " R6 low after commit"});
    idle(RLK - 1);
    chk({31'd0, pll_locked}, 32'd0, {tag, " R6 still low"});
    idle(1);
    chk({31'd0, pll_locked}, 32'd1, {tag, " R6 relocked"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] wref, wfb, wpost;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d); chk(d, 32'h2000, "R1 reset word");
    end
    rd(2'd3, d); chk(d, 32'h1, "R1 reset status");
    chk({25'd0, ratio_ref}, 1, "R1 ratio_ref");
    chk({25'd0, ratio_fb}, 1, "R1 ratio_fb");
    chk({25'd0, ratio_post}, 1, "R1 ratio_post");

    // R3 hold write stages only; R2 reserved bits read as zero
    wref = mk(3, 4, 0, 0, 1);
    wr(2'd0, wref | 32'hFFFF_8000);
    rd(2'd0, d); chk(d, wref, "R2 readback masks 31:15");
    chk({25'd0, ratio_ref}, 1, "R3 ratio_ref unchanged");
    chk({31'd0, pll_locked}, 1, "R3 lock unchanged");
    idle(2);
    chk({31'd0, pll_locked}, 1, "R3 no relock");

    // R4 R5 commit of all three, edge bit no effect
    wfb = mk(10, 5, 1, 0, 1);
    wr(2'd1, wfb);
    rd(2'd1, d); chk(d, wfb, "R2 feedback at word 1");
    chk({25'd0, ratio_fb}, 1, "R3 ratio_fb staged only");
    wpost = mk(2, 2, 0, 0, 0);
    wr(2'd2, wpost);
    chk({25'd0, ratio_ref}, 7, "R4 ratio_ref committed");
    chk({25'd0, ratio_fb}, 15, "R5 ratio_fb with edge bit");
    chk({25'd0, ratio_post}, 4, "R4 ratio_post committed");
    rd(2'd2, d); chk(d, wpost, "R2 post at word 2");
    relock_check("basic");

    // R9 status writes ignored
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk(d, 32'h1, "R9 status unchanged");
    chk({25'd0, ratio_post}, 4, "R9 ratios unchanged");
    idle(1);
    chk({31'd0, pll_locked}, 1, "R9 no relock");
    rd(2'd0, d); chk(d, wref, "R9 word0 unchanged");

    // R8 error at commit, sticky, relock still completes
    wr(2'd0, mk(0, 0, 0, 0, 0));
    chk({31'd0, cfg_error}, 1, "R8 error on zero ratio");
    relock_check("err");
    wr(2'd1, mk(1, 1, 0, 0, 1));
    chk({31'd0, cfg_error}, 1, "R8 error held on hold write");
    rd(2'd3, d); chk(d, 32'h3, "R8 status both bits");
    wr(2'd0, mk(0, 0, 0, 1, 0));
    chk({31'd0, cfg_error}, 0, "R8 bypass zero counts legal");
    chk({25'd0, ratio_ref}, 1, "R5 bypass ratio");
    chk({25'd0, ratio_fb}, 2, "R4 staged fb now active");
    relock_check("clr");

    // R7 restart during relock
    wr(2'd2, mk(1, 2, 0, 0, 0));
    idle(3);
    chk({31'd0, pll_locked}, 0, "R7 low mid relock");
    wr(2'd2, mk(2, 2, 0, 0, 0));
    relock_check("R7 restart");

    // R5 R8 sweep over post divider counts
    for (int h = 0; h < 64; h += 5) begin
      for (int l = 0; l < 64; l += 7) begin
        logic [31:0] w;
        w = mk(h, l, (h + l) % 2 == 1, 0, 0);
        wr(2'd2, w);
        chk({25'd0, ratio_post}, exp_ratio(w), "R5 sweep ratio");
        chk({31'd0, cfg_error}, 32'(h + l == 0), "R8 sweep error");
        idle(RLK);
        chk({31'd0, pll_locked}, 1, "R6 sweep relock");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule